// File: doc/BRIEF.md
# Paged Nonvolatile Write-Buffer Controller

This block is the device-side control logic of a byte-wide paged nonvolatile memory, written as a synchronous model. It samples three active-low strobes each clock: chip enable, output enable and write enable. It also samples an address and the incoming half of the data bus. Byte loads are gathered into a 128-byte page buffer. The page buffer has a per-byte loaded mask. A load is held open by a retriggerable timer that restarts on each accepted load. When the timer runs out, a self-timed programming phase copies only the loaded bytes into the storage array. During this busy phase, reads return a status byte in place of array data.

The bidirectional data bus is split into `dq_i`, `dq_o` and the drive enable `dq_oe`. `dq_oe` low stands for high impedance. The array holds 2^ADDR_W bytes. A full-size configuration sets ADDR_W to 16, giving 64K bytes. The default is 12 so that elaboration stays small. The inter-load timeout and the programming length are given as clock-cycle parameters.

Top module: `pnv_page_ctrl`

## Requirements
- R1: `dq_oe` is 1 in the cycle after a clock edge that sampled both chip enable and output enable low, and 0 after any edge where either was high. Reads outside programming return the array byte at the sampled address with the same one-cycle latency.
- R2: A load begins only when chip enable and write enable are both low while output enable is high. With output enable low, the same strobes load nothing and start no programming.
- R3: The address is taken when the later of chip enable and write enable falls. The data is taken on the edge where the first of the two returns high.
- R4: Address bits [ADDR_W-1:7] select the page and bits [6:0] select the byte in it. The first load fixes the page, and a later load aimed at another page is ignored.
- R5: Programming writes only the bytes loaded since the last commit, and the last load to an offset wins. Unloaded bytes of the page keep their previous contents.
- R6: Each accepted load restarts the inter-load timer. Programming starts once TLOAD_CYC cycles pass after the last accepted load start with no load in progress. Total loading time has no limit.
- R7: `busy` stays high for exactly PROG_CYC cycles. Loads attempted while it is high are ignored.
- R8: While busy, a read returns the inverse of bit 7 of the last loaded byte on bit 7 and that byte's bits [5:0] unchanged on bits [5:0].
- R9: While busy, bit 6 of the read data inverts on each new read.
- R10: After programming, reads return the committed data.
- R11: After reset, `busy` and `dq_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chip_en_n | input | 1 | Chip enable, active low |
| out_en_n | input | 1 | Output enable, active low |
| wr_en_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| dq_i | input | 8 | Data bus, inbound |
| dq_o | output | 8 | Data bus, outbound |
| dq_oe | output | 1 | Data bus drive enable (0 = high impedance) |
| busy | output | 1 | Programming phase in progress |

## Verification
Most internal faults show at the ports only one programming phase later.

- A wrong loaded mask or page register corrupts or skips bytes. This is seen on the first read after `busy` falls.
- A wrong timer shows as `busy` rising too early, while loads are still spaced inside the window, or too late.
- A wrong programming counter changes the measured length of `busy`.
- Faults in the status path show on the very next read during busy. They appear as a bit 7 that is not inverted, or a bit 6 that fails to differ between two reads.

// File: rtl/pnv_pkg.sv
package pnv_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOAD = 2'd1,
      ST_PROG = 2'd2
   } pnv_state_e;

   localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/pnv_strobe.sv
module pnv_strobe (
   input  logic clk,
   input  logic rst_n,
   input  logic chip_en_n,
   input  logic out_en_n,
   input  logic wr_en_n,
   output logic wr_start,
   output logic wr_end,
   output logic rd_act,
   output logic rd_start
);
   logic wact_d, wact_q, rd_q;

   assign wact_d   = ~chip_en_n & ~wr_en_n;
   assign rd_act   = ~chip_en_n & ~out_en_n;
   // later of the two falling strobes, only with output enable high
   assign wr_start = wact_d & ~wact_q & out_en_n;
   // first of the two strobes returning high
   assign wr_end   = ~wact_d & wact_q;
   assign rd_start = rd_act & ~rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wact_q <= 1'b0;
         rd_q   <= 1'b0;
      end else begin
         wact_q <= wact_d;
         rd_q   <= rd_act;
      end
   end
endmodule

// File: rtl/pnv_page_buf.sv
module pnv_page_buf #(
   parameter int unsigned OFF_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_en,
   input  logic [OFF_W-1:0] ld_off,
   input  logic [7:0]       ld_data,
   input  logic             clr,
   input  logic [OFF_W-1:0] scan_off,
   output logic [7:0]       scan_byte,
   output logic             scan_valid
);
   localparam int unsigned PAGE_BYTES = 1 << OFF_W;

   if (OFF_W < 1 || OFF_W > 10) begin : g_bad_off
      $error("pnv_page_buf: OFF_W out of range");
   end

   logic [7:0]            bytes_q [PAGE_BYTES];
   logic [PAGE_BYTES-1:0] vld_q;

   always_ff @(posedge clk) begin
      if (ld_en) bytes_q[ld_off] <= ld_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      vld_q <= '0;
      else if (clr)    vld_q <= '0;
      else if (ld_en)  vld_q[ld_off] <= 1'b1;
   end

   assign scan_byte  = bytes_q[scan_off];
   assign scan_valid = vld_q[scan_off];

   // R5
   ld_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && !clr) |=> vld_q[$past(ld_off)]);
endmodule

// File: rtl/pnv_seq.sv
module pnv_seq
   import pnv_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned OFF_W     = 7,
   parameter int unsigned TLOAD_CYC = 40,
   parameter int unsigned PROG_CYC  = 200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_start,
   input  logic              wr_end,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        dq_i,
   output logic              ld_en,
   output logic [OFF_W-1:0]  ld_off,
   output logic [7:0]        ld_data,
   output logic              buf_clr,
   output logic [OFF_W-1:0]  scan_off,
   input  logic              scan_valid,
   input  logic [7:0]        scan_byte,
   output logic              arr_we,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [7:0]        arr_data,
   output logic              busy,
   output logic [7:0]        last_data
);
   localparam int unsigned PAGE_W     = ADDR_W - OFF_W;
   localparam int unsigned PAGE_BYTES = 1 << OFF_W;
   localparam int unsigned TM_W       = $clog2(TLOAD_CYC + 1);
   localparam int unsigned PC_W       = $clog2(PROG_CYC + 1);

   if (PROG_CYC < PAGE_BYTES) begin : g_bad_prog
      $error("pnv_seq: PROG_CYC must cover one scan of the page");
   end
   if (TLOAD_CYC < 2) begin : g_bad_tload
      $error("pnv_seq: TLOAD_CYC too small");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("pnv_seq: ADDR_W must exceed OFF_W");
   end

   pnv_state_e        state_q;
   logic [PAGE_W-1:0] page_q;
   logic [OFF_W-1:0]  off_q;
   logic              armed_q;
   logic [TM_W-1:0]   tmr_q;
   logic [PC_W-1:0]   pcnt_q;
   logic              accept, expire, scanning, prog_done;

   assign accept    = wr_start && (state_q != ST_PROG) &&
                      (state_q == ST_IDLE || addr[ADDR_W-1:OFF_W] == page_q);
   assign expire    = (state_q == ST_LOAD) && !armed_q && !accept &&
                      (tmr_q >= TM_W'(TLOAD_CYC - 1));
   assign scanning  = (state_q == ST_PROG) && (pcnt_q < PC_W'(PAGE_BYTES));
   assign prog_done = (state_q == ST_PROG) && (pcnt_q == PC_W'(PROG_CYC - 1));

   assign ld_en    = armed_q && wr_end;
   assign ld_off   = off_q;
   assign ld_data  = dq_i;
   assign buf_clr  = prog_done;
   assign scan_off = pcnt_q[OFF_W-1:0];
   assign arr_we   = scanning && scan_valid;
   assign arr_addr = {page_q, scan_off};
   assign arr_data = scan_byte;
   assign busy     = (state_q == ST_PROG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         page_q    <= '0;
         off_q     <= '0;
         armed_q   <= 1'b0;
         tmr_q     <= '0;
         pcnt_q    <= '0;
         last_data <= '0;
      end else begin
         if (ld_en) begin
            armed_q   <= 1'b0;
            last_data <= dq_i;
         end
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  state_q <= ST_LOAD;
                  page_q  <= addr[ADDR_W-1:OFF_W];
                  off_q   <= addr[OFF_W-1:0];
                  armed_q <= 1'b1;
                  tmr_q   <= '0;
               end
            end
            ST_LOAD: begin
               if (accept) begin
                  off_q   <= addr[OFF_W-1:0];
                  armed_q <= 1'b1;
                  tmr_q   <= '0;
               end else if (expire) begin
                  state_q <= ST_PROG;
                  pcnt_q  <= '0;
               end else if (tmr_q != TM_W'(TLOAD_CYC)) begin
                  tmr_q <= tmr_q + 1'b1;
               end
            end
            ST_PROG: begin
               if (prog_done) state_q <= ST_IDLE;
               else           pcnt_q  <= pcnt_q + 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R6
   early_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_LOAD && tmr_q < TM_W'(TLOAD_CYC - 1)) |=> state_q != ST_PROG);

   // R7
   prog_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PROG) |-> !ld_en);

   // R7
   prog_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PROG && pcnt_q < PC_W'(PROG_CYC - 1)) |=> state_q == ST_PROG);
endmodule

// File: rtl/pnv_array.sv
module pnv_array #(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned OFF_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [7:0]        wdata,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] raddr,
   input  logic              use_status,
   input  logic [7:0]        status,
   output logic [7:0]        rdata
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   if (ADDR_W > 16) begin : g_bad_depth
      $error("pnv_array: ADDR_W above 16 not supported");
   end

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= use_status ? status : mem[raddr];
   end

   // R4
   one_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && $past(we)) |-> waddr[ADDR_W-1:OFF_W] == $past(waddr[ADDR_W-1:OFF_W]));
endmodule

// File: rtl/pnv_page_ctrl.sv
module pnv_page_ctrl #(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned TLOAD_CYC = 40,
   parameter int unsigned PROG_CYC  = 200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chip_en_n,
   input  logic              out_en_n,
   input  logic              wr_en_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        dq_i,
   output logic [7:0]        dq_o,
   output logic              dq_oe,
   output logic              busy
);
   localparam int unsigned OFF_W = 7;

   logic wr_start, wr_end, rd_act, rd_start;
   logic ld_en, buf_clr, scan_valid, arr_we;
   logic [OFF_W-1:0]  ld_off, scan_off;
   logic [7:0]        ld_data, scan_byte, arr_data, last_data, status;
   logic [ADDR_W-1:0] arr_addr;
   logic              tog_q, tog_nxt, oe_q;

   pnv_strobe u_strobe (
      .clk(clk), .rst_n(rst_n), .chip_en_n(chip_en_n), .out_en_n(out_en_n),
      .wr_en_n(wr_en_n), .wr_start(wr_start), .wr_end(wr_end),
      .rd_act(rd_act), .rd_start(rd_start)
   );

   pnv_page_buf #(.OFF_W(OFF_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_off(ld_off),
      .ld_data(ld_data), .clr(buf_clr), .scan_off(scan_off),
      .scan_byte(scan_byte), .scan_valid(scan_valid)
   );

   pnv_seq #(
      .ADDR_W(ADDR_W), .OFF_W(OFF_W), .TLOAD_CYC(TLOAD_CYC), .PROG_CYC(PROG_CYC)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_end(wr_end),
      .addr(addr), .dq_i(dq_i), .ld_en(ld_en), .ld_off(ld_off),
      .ld_data(ld_data), .buf_clr(buf_clr), .scan_off(scan_off),
      .scan_valid(scan_valid), .scan_byte(scan_byte), .arr_we(arr_we),
      .arr_addr(arr_addr), .arr_data(arr_data), .busy(busy),
      .last_data(last_data)
   );

   // toggle flips once per new read while busy
   assign tog_nxt = tog_q ^ (rd_start & busy);
   assign status  = {~last_data[7], tog_nxt, last_data[5:0]};

   pnv_array #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_arr (
      .clk(clk), .rst_n(rst_n), .we(arr_we), .waddr(arr_addr),
      .wdata(arr_data), .rd_en(rd_act), .raddr(addr),
      .use_status(busy), .status(status), .rdata(dq_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tog_q <= 1'b0;
         oe_q  <= 1'b0;
      end else begin
         tog_q <= tog_nxt;
         oe_q  <= rd_act;
      end
   end

   assign dq_oe = oe_q;

   // R1
   bus_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> $past(!chip_en_n && !out_en_n));

   // R9
   toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_start && busy) |=> (dq_o[6] != $past(tog_q)));
endmodule

// File: tb/pnv_page_ctrl_tb.sv
module pnv_page_ctrl_tb_top;
   localparam int ADDR_W = 12;
   localparam int TLOAD  = 40;
   localparam int PROG   = 200;
   localparam int DEPTH  = 1 << ADDR_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic chip_en_n = 1'b1, out_en_n = 1'b1, wr_en_n = 1'b1;
   logic [ADDR_W-1:0] addr = '0;
   logic [7:0] dq_i = '0;
   logic [7:0] dq_o;
   logic dq_oe, busy;

   always #10 clk = ~clk;

   pnv_page_ctrl #(.ADDR_W(ADDR_W), .TLOAD_CYC(TLOAD), .PROG_CYC(PROG)) dut_i (
      .clk(clk), .rst_n(rst_n), .chip_en_n(chip_en_n), .out_en_n(out_en_n),
      .wr_en_n(wr_en_n), .addr(addr), .dq_i(dq_i), .dq_o(dq_o),
      .dq_oe(dq_oe), .busy(busy)
   );

   int errs = 0, checks = 0;
   bit done = 0;
   logic [7:0] model [DEPTH];
   bit known [DEPTH];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 7 + 3) ^ (a >> 3));
   endfunction

   task automatic do_load(input int a, input logic [7:0] d);
      @(negedge clk);
      addr = ADDR_W'(a); dq_i = d; out_en_n = 1'b1; chip_en_n = 1'b0; wr_en_n = 1'b0;
      repeat (2) @(negedge clk);
      chip_en_n = 1'b1; wr_en_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic do_read(input int a, output logic [7:0] v);
      @(negedge clk);
      addr = ADDR_W'(a); chip_en_n = 1'b0; out_en_n = 1'b0;
      @(negedge clk);
      v = dq_o;
      chk(dq_oe === 1'b1, "R1 drive", int'(dq_oe), 1);
      chip_en_n = 1'b1; out_en_n = 1'b1;
      @(negedge clk);
      chk(dq_oe === 1'b0, "R1 hiz", int'(dq_oe), 0);
   endtask

   task automatic wait_commit(input string req);
      int len = 0;
      int w = 0;
      while (!busy && w < TLOAD + 10) begin @(negedge clk); w++; end
      chk(busy === 1'b1, req, int'(busy), 1);
      while (busy && len < PROG + 10) begin @(negedge clk); len++; end
      // R7 busy length
      chk(len == PROG, "R7 length", len, PROG);
   endtask

   task automatic check_mem(input int a, input string req);
      logic [7:0] v;
      do_read(a, v);
      chk(v === model[a], req, int'(v), int'(model[a]));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errs++; checks++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("  Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] v, v2;
      int unused;
      unused = $urandom(32'h5eed_1234);
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(busy === 1'b0, "R11 busy", int'(busy), 0);
      chk(dq_oe === 1'b0, "R11 dq_oe", int'(dq_oe), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // full pages 0 and 1, each a separate commit
      for (int p = 0; p < 2; p++) begin
         for (int o = 0; o < 128; o++) begin
            do_load(p * 128 + o, pat(p * 128 + o));
            model[p * 128 + o] = pat(p * 128 + o); known[p * 128 + o] = 1;
         end
         wait_commit("R6 full page start");
      end
      for (int a = 0; a < 256; a += 37) check_mem(a, "R10 full page");

      // partial page with an off-page load mixed in
      do_load(5, 8'hA5);   model[5] = 8'hA5;
      do_load(128 + 3, 8'h77); // R4 other page: ignored
      do_load(9, 8'h3C);   model[9] = 8'h3C;
      do_load(5, 8'h5B);   model[5] = 8'h5B;
      wait_commit("R6 partial start");
      check_mem(5, "R5 last load wins");
      check_mem(9, "R5 loaded byte");
      check_mem(6, "R5 unloaded keeps old");
      check_mem(128 + 3, "R4 off-page ignored");

      // status during programming
      do_load(128 + 10, 8'h5A); model[128 + 10] = 8'h5A;
      while (!busy) @(negedge clk);
      do_read(128 + 10, v);
      chk(v[7] == 1'b1, "R8 bit7 inverted", int'(v[7]), 1);
      chk(v[5:0] == 6'h1A, "R8 low bits", int'(v[5:0]), 'h1A);
      do_read(7, v2);
      chk(v2[6] != v[6], "R9 toggle", int'(v2[6]), int'(~v[6]));
      do_read(7, v);
      chk(v[6] != v2[6], "R9 toggle again", int'(v[6]), int'(~v2[6]));
      do_load(128 + 11, 8'hEE); // R7 ignored while busy
      while (busy) @(negedge clk);
      check_mem(128 + 10, "R10 after busy");
      check_mem(128 + 11, "R7 load while busy ignored");

      // R6 retriggered timer
      do_load(20, 8'h81); model[20] = 8'h81;
      repeat (30) @(negedge clk);
      chk(busy === 1'b0, "R6 open window", int'(busy), 0);
      do_load(21, 8'h82); model[21] = 8'h82;
      repeat (30) @(negedge clk);
      chk(busy === 1'b0, "R6 retriggered", int'(busy), 0);
      repeat (TLOAD) @(negedge clk);
      chk(busy === 1'b1, "R6 timeout start", int'(busy), 1);
      while (busy) @(negedge clk);
      check_mem(20, "R6 data");
      check_mem(21, "R6 data");

      // R2 write strobes with output enable low
      @(negedge clk);
      addr = ADDR_W'(30); dq_i = 8'h00; out_en_n = 1'b0; chip_en_n = 1'b0; wr_en_n = 1'b0;
      repeat (3) @(negedge clk);
      chip_en_n = 1'b1; wr_en_n = 1'b1; out_en_n = 1'b1;
      repeat (TLOAD + 10) @(negedge clk);
      chk(busy === 1'b0, "R2 no programming", int'(busy), 0);
      check_mem(30, "R2 no load");

      // R3 chip-enable controlled load
      @(negedge clk);
      addr = ADDR_W'(900); dq_i = 8'h11; wr_en_n = 1'b0;
      @(negedge clk);
      addr = ADDR_W'(31); chip_en_n = 1'b0;
      @(negedge clk);
      addr = ADDR_W'(900); dq_i = 8'hC3;
      @(negedge clk);
      chip_en_n = 1'b1;
      @(negedge clk);
      dq_i = 8'h99; wr_en_n = 1'b1;
      model[31] = 8'hC3;
      wait_commit("R3 start");
      check_mem(31, "R3 capture points");
      check_mem(900 & 127, "R3 other address untouched");

      // constrained random pages
      for (int it = 0; it < 5; it++) begin
         int pg = 8 + it;
         int n = 1 + int'($urandom % 16);
         for (int k = 0; k < n; k++) begin
            int a = pg * 128 + int'($urandom % 128);
            logic [7:0] d = 8'($urandom);
            do_load(a, d); model[a] = d; known[a] = 1;
         end
         wait_commit("R6 random start");
         for (int o = 0; o < 128; o++)
            if (known[pg * 128 + o]) check_mem(pg * 128 + o, "R10 random");
      end

      done = 1;
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule